// File: doc/BRIEF.md
# Speed Select Wait-State Generator

This block stretches every memory bus cycle by a number of wait states that host software picks. Two byte-wide I/O registers are decoded on the host port. One bit from each register is combined into a two-bit speed code. A fixed table turns that code into a wait-state count: 94, 47, 24 or 0 clocks.

A bus master raises `cyc_req` to start a cycle and holds it until `rdy` goes high. The block captures the wait-state count in the clock where the request first appears. It keeps `rdy` low for exactly that many clocks and then raises it for one clock. A request held high again in the next clock starts a new cycle.

The speed is set by writing both registers. The pairs written to (0x674, 0x670) are (0x25, 0x00) for code 0, (0x80, 0x00) for code 1, (0x00, 0x01) for code 2 and (0x80, 0x01) for code 3. Both registers read back through the same port.

Top module: `spd_ws_gen`

## Requirements
- R1: After reset both registers read 0x00 and the speed code is 0, so the first cycle takes 94 wait states.
- R2: A write with `io_wr` high stores all eight bits of `io_wdata` into the register whose address matches: 0x670 for register A, 0x674 for register B. `io_rdata` returns the full stored byte for a matching address and 0x00 for any other address. Writes to any other address change neither register.
- R3: The speed code takes bit 1 from bit 0 of register A and bit 0 from bit 7 of register B. No other bit of either register changes the wait count.
- R4: Code 0 selects 94 wait states, code 1 selects 47, code 2 selects 24 and code 3 selects 0.
- R5: For a cycle with N > 0 wait states that starts in clock 0, `rdy` is low in clocks 0 through N-1 and high in clock N.
- R6: For a zero-wait cycle, `rdy` is high in the same clock as the request.
- R7: A request held high in the clock after `rdy` starts a new cycle at once. At code 3, a request held high continuously gets `rdy` in every clock.
- R8: A register write made while a cycle is in progress does not change the length of that cycle. It applies only to cycles that start afterwards.
- R9: `rdy` stays low while the block is idle and no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | Host I/O write strobe, one clock per write |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host I/O write data |
| io_rdata | output | 8 | Read-back data for the addressed register, 0 for any other address |
| cyc_req | input | 1 | Bus cycle request, held high until `rdy` |
| rdy | output | 1 | Cycle ready, high in the last clock of the cycle |

## Verification
The assertions assume that `cyc_req`, once raised, stays high up to and including the clock where `rdy` is high. Their cycle-length window counter restarts only on an idle-to-busy step. The stimulus keeps to this rule: it raises the request at a falling edge and drops it only at the falling edge that follows the ready clock. Register writes are single-clock strobes, and the bench also makes them in the middle of a wait so that the latched count can be seen to hold.

// File: rtl/spd_ws_pkg.sv
package spd_ws_pkg;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_WAIT = 1'b1
    } ws_state_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/spd_port_regs.sv
module spd_port_regs #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int PORT_A   = 'h670,
    parameter int PORT_B   = 'h674,
    parameter int A_BIT    = 0,
    parameter int B_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [1:0]        code
);

    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(PORT_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(PORT_B);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  sel_a, sel_b;

    always_comb begin
        sel_a  = (io_addr == ADDR_A);
        sel_b  = (io_addr == ADDR_B);
        regs_d = regs_q;
        if (io_wr && sel_a) regs_d.a = io_wdata;
        if (io_wr && sel_b) regs_d.b = io_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (sel_a)      io_rdata = regs_q.a;
        else if (sel_b) io_rdata = regs_q.b;
        else            io_rdata = '0;
    end

    assign reg_a = regs_q.a;
    assign reg_b = regs_q.b;
    assign code  = {regs_q.a[A_BIT], regs_q.b[B_BIT]};

endmodule

// File: rtl/spd_ws_table.sv
module spd_ws_table #(
    parameter int CNT_W  = 7,
    parameter int WAIT_0 = 94,
    parameter int WAIT_1 = 47,
    parameter int WAIT_2 = 24,
    parameter int WAIT_3 = 0
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] wsel
);

    localparam int NCODE = 4;

    logic [CNT_W-1:0] tbl [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_entry
        localparam int VAL = (g == 0) ? WAIT_0 :
                             (g == 1) ? WAIT_1 :
                             (g == 2) ? WAIT_2 : WAIT_3;
        assign tbl[g] = CNT_W'(VAL);
    end

    assign wsel = tbl[code];

endmodule

// File: rtl/spd_ws_counter.sv
module spd_ws_counter
    import spd_ws_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_req,
    input  logic [CNT_W-1:0] wsel,
    output logic             rdy,
    output logic             busy
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        ws_state_e        state;
        logic [CNT_W-1:0] remain;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic last;
    logic zero_hit;

    always_comb begin
        ctr_d    = ctr_q;
        last     = (ctr_q.state == WS_WAIT) && (ctr_q.remain == ONE);
        zero_hit = (ctr_q.state == WS_IDLE) && cyc_req && (wsel == '0);
        rdy      = last || zero_hit;
        case (ctr_q.state)
            WS_IDLE: begin
                if (cyc_req && (wsel != '0)) begin
                    ctr_d.state  = WS_WAIT;
                    ctr_d.remain = wsel;
                end
            end
            default: begin
                ctr_d.remain = ctr_q.remain - ONE;
                if (last) ctr_d.state = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '{state: WS_IDLE, remain: '0};
        else        ctr_q <= ctr_d;
    end

    assign busy = (ctr_q.state == WS_WAIT);

endmodule

// File: rtl/spd_ws_gen.sv
module spd_ws_gen #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PORT_A = 'h670,
    parameter int PORT_B = 'h674,
    parameter int A_BIT  = 0,
    parameter int B_BIT  = 7,
    parameter int WAIT_0 = 94,
    parameter int WAIT_1 = 47,
    parameter int WAIT_2 = 24,
    parameter int WAIT_3 = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              cyc_req,
    output logic              rdy
);

    localparam int MAX_WAIT = spd_ws_pkg::max4(WAIT_0, WAIT_1, WAIT_2, WAIT_3);
    localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

    logic [DATA_W-1:0] reg_a, reg_b;
    logic [1:0]        code;
    logic [CNT_W-1:0]  wsel;
    logic              busy;

    spd_port_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PORT_A(PORT_A), .PORT_B(PORT_B),
        .A_BIT(A_BIT),   .B_BIT(B_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .reg_a(reg_a), .reg_b(reg_b), .code(code)
    );

    spd_ws_table #(
        .CNT_W(CNT_W),
        .WAIT_0(WAIT_0), .WAIT_1(WAIT_1), .WAIT_2(WAIT_2), .WAIT_3(WAIT_3)
    ) u_table (
        .code(code),
        .wsel(wsel)
    );

    spd_ws_counter #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .cyc_req(cyc_req), .wsel(wsel),
        .rdy(rdy), .busy(busy)
    );

endmodule

// File: rtl/spd_ws_gen_chk.sv
module spd_ws_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PORT_A = 'h670,
    parameter int PORT_B = 'h674,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic              cyc_req,
    input logic              rdy,
    input logic              busy,
    input logic [CNT_W-1:0]  wsel,
    input logic [DATA_W-1:0] reg_a,
    input logic [DATA_W-1:0] reg_b
);

    logic [CNT_W-1:0] seen_q;
    logic [CNT_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
            len_q  <= '0;
        end else if (!busy && cyc_req) begin
            seen_q <= CNT_W'(1);
            len_q  <= wsel;
        end else if (busy) begin
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    // R5
    wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rdy |-> seen_q == len_q);

    // R5
    no_early_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (seen_q < len_q) |-> !rdy);

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rdy |=> busy && $stable(len_q));

    // R6
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cyc_req && (wsel == '0) |-> rdy);

    // R7
    b2b_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rdy |=> !busy);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !cyc_req |-> !rdy);

    // R2
    reg_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && (io_addr == ADDR_W'(PORT_A))) |=> $stable(reg_a));

    // R2
    reg_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && (io_addr == ADDR_W'(PORT_B))) |=> $stable(reg_b));

endmodule

bind spd_ws_gen spd_ws_gen_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PORT_A(PORT_A), .PORT_B(PORT_B),
    .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .io_wr(io_wr), .io_addr(io_addr),
    .cyc_req(cyc_req), .rdy(rdy),
    .busy(busy), .wsel(wsel),
    .reg_a(reg_a), .reg_b(reg_b)
);

// File: tb/tb_spd_ws_gen.sv
module tb_spd_ws_gen;

    localparam int CLK_PERIOD = 10;
    localparam int PA = 'h670;
    localparam int PB = 'h674;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cyc_req = 1'b0;
    logic        rdy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    spd_ws_gen dut (
        .clk(clk), .rst_n(rst_n),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .cyc_req(cyc_req), .rdy(rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_wait(input logic [7:0] a, input logic [7:0] b);
        int c;
        c = 2 * int'(a[0]) + int'(b[7]);
        case (c)
            0: return 94;
            1: return 47;
            2: return 24;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic io_write(input int addr, input logic [7:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_addr = 16'(addr); io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input int addr, output logic [7:0] data);
        io_addr = 16'(addr);
        #1;
        data = io_rdata;
    endtask

    // Called at a falling edge; returns at the falling edge after the ready clock.
    task automatic do_cycle(input int expv, input string req, input bit keep);
        int n = 0;
        cyc_req = 1'b1;
        #1;
        while (!rdy && n < 300) begin
            @(negedge clk);
            n++;
            #1;
        end
        check(n == expv, req, n, expv);
        @(negedge clk);
        if (!keep) cyc_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] a_vals [4];
        a_vals[0] = 8'h00; a_vals[1] = 8'h01; a_vals[2] = 8'hFE; a_vals[3] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        io_read(PA, rd); check(rd == 8'h00, "R1 reg A reset", rd, 0);
        io_read(PB, rd); check(rd == 8'h00, "R1 reg B reset", rd, 0);
        // R9: idle, no request
        #1 check(rdy == 1'b0, "R9 idle rdy", rdy, 0);
        do_cycle(94, "R1 first cycle length", 1'b0);

        // R4: documented software pairs
        io_write(PB, 8'h25); io_write(PA, 8'h00); do_cycle(94, "R4 code0", 1'b0);
        io_write(PB, 8'h80); io_write(PA, 8'h00); do_cycle(47, "R4 code1", 1'b0);
        io_write(PB, 8'h00); io_write(PA, 8'h01); do_cycle(24, "R4 code2", 1'b0);
        io_write(PB, 8'h80); io_write(PA, 8'h01); do_cycle(0,  "R6 code3 zero wait", 1'b0);

        // R2: non-matching addresses are ignored
        io_write('h671, 8'h00); io_write('h675, 8'h00);
        io_write('h470, 8'h00); io_write('h1674, 8'h00);
        io_read(PA, rd); check(rd == 8'h01, "R2 reg A untouched", rd, 1);
        io_read(PB, rd); check(rd == 8'h80, "R2 reg B untouched", rd, 'h80);
        io_read('h672, rd); check(rd == 8'h00, "R2 other addr reads 0", rd, 0);
        do_cycle(0, "R2 speed unchanged", 1'b0);

        // R7: continuous zero-wait requests
        cyc_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #1 check(rdy == 1'b1, "R7 ready every clock", rdy, 1);
            @(negedge clk);
        end
        cyc_req = 1'b0;
        #1 check(rdy == 1'b0, "R9 idle after burst", rdy, 0);

        // R7: back-to-back nonzero cycles
        io_write(PB, 8'h00);
        do_cycle(24, "R7 first of pair", 1'b1);
        do_cycle(24, "R7 second of pair", 1'b0);

        // R8: write in mid-cycle
        io_write(PB, 8'h00); io_write(PA, 8'h00);
        begin
            int n = 0;
            cyc_req = 1'b1;
            #1;
            while (!rdy && n < 300) begin
                @(negedge clk);
                n++;
                if (n == 5) begin io_wr = 1'b1; io_addr = 16'(PA); io_wdata = 8'h01; end
                else if (n == 6) begin io_addr = 16'(PB); io_wdata = 8'h80; end
                else if (n == 7) io_wr = 1'b0;
                #1;
            end
            check(n == 94, "R8 cycle length kept", n, 94);
            @(negedge clk);
            cyc_req = 1'b0;
        end
        do_cycle(0, "R8 new speed on next cycle", 1'b0);

        // R2 R3 R4 R5: sweep of register B against four register A values
        for (int ai = 0; ai < 4; ai++) begin
            for (int b = 0; b < 256; b++) begin
                io_write(PA, a_vals[ai]);
                io_write(PB, 8'(b));
                io_read(PA, rd); check(rd == a_vals[ai], "R2 sweep readback A", rd, a_vals[ai]);
                io_read(PB, rd); check(rd == 8'(b), "R2 sweep readback B", rd, b);
                do_cycle(exp_wait(a_vals[ai], 8'(b)), "R3 R5 sweep wait count", 1'b0);
            end
        end

        // R1: reset mid-state returns to slowest speed
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        io_read(PA, rd); check(rd == 8'h00, "R1 reg A after reset", rd, 0);
        do_cycle(94, "R1 speed after reset", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule